// File: doc/BRIEF.md
# Register Rename Map Table

This block keeps, for a two-wide rename stage, the speculative translation from each architectural register number to the physical register that currently holds its value. In every cycle both instructions of the group look up their two source registers and the old mapping of their destination. That old mapping is the stale physical register, which is released when the instruction retires. Instructions that write a register then install the physical register handed to them by the free list. When the older instruction of a group writes a register that the younger one names, the younger one sees the new mapping in the same cycle.

Each lane can save a copy of the table into one of several checkpoint slots, selected by a branch tag. The copy includes every mapping written up to and including that lane. A mispredict names a tag, and the table returns to that copy in one cycle. A second, committed table follows retirement. On an exception or flush, the speculative table is reloaded from it in one cycle. Architectural register zero always maps to physical register zero, and writes to it are ignored.

Top module: `rename_map_table`

## Requirements
- R1: While reset is asserted, the speculative table, the committed table and every checkpoint slot load the identity mapping: architectural register r maps to physical register r.
- R2: The source outputs are combinational. In lane 0 they show the table entry for each source register. Architectural register 0 always gives physical register 0.
- R3: When lane 0 is valid and writes a nonzero register that a lane 1 source or destination names, lane 1 gets lane 0's new physical register in the same cycle. This applies to its source outputs and to its stale output.
- R4: The stale output of a lane is the mapping of its destination before the lane's own write. Its flag is 1 only when the lane is valid, writes a register, and has a nonzero destination. A write to register 0 changes no mapping.
- R5: A write becomes visible to lookups in the cycle after it is presented. When both lanes write the same register, lane 1's physical register is the one kept.
- R6: A checkpoint request on lane 0 stores the table with lane 0's write applied. A request on lane 1 stores the table with both lanes' writes applied. Each copy goes into the slot given by that lane's tag.
- R7: A mispredict with tag t loads slot t into the table in one cycle. The group's writes in that cycle are dropped.
- R8: Checkpoint requests that arrive in the same cycle as a mispredict or flush are dropped, and the slot keeps its old contents.
- R9: Each valid commit lane with a nonzero destination updates the committed table with its physical register. Lane 1 wins when both lanes name the same register.
- R10: A flush loads the committed table, including commits made in the same cycle, into the speculative table in one cycle. A flush takes precedence over a mispredict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 2 | Lane holds an instruction |
| ren_wen_i | input | 2 | Lane writes a destination register |
| ren_rs1_i | input | 2x5 | First source register, per lane |
| ren_rs2_i | input | 2x5 | Second source register, per lane |
| ren_rd_i | input | 2x5 | Destination register, per lane |
| ren_pdst_i | input | 2x6 | New physical register for the destination |
| ren_prs1_o | output | 2x6 | Physical register of the first source |
| ren_prs2_o | output | 2x6 | Physical register of the second source |
| ren_stale_o | output | 2x6 | Previous physical register of the destination |
| ren_stale_vld_o | output | 2 | Stale output is meaningful |
| br_snap_i | input | 2 | Take a checkpoint after this lane |
| br_tag_i | input | 2x2 | Checkpoint slot, per lane |
| mispred_i | input | 1 | Restore from a checkpoint |
| mispred_tag_i | input | 2 | Slot to restore from |
| flush_i | input | 1 | Restore from the committed table |
| cmt_valid_i | input | 2 | Commit lane retires a register write |
| cmt_rd_i | input | 2x5 | Retiring destination register |
| cmt_pdst_i | input | 2x6 | Retiring physical register |

## Verification
The bench goes after four faults:
- Missing bypass. Both lanes write one register and lane 1 also reads it. A design without the bypass would hand lane 1 a stale source.
- Wrong checkpoint content. A lane 0 checkpoint must not contain lane 1's write. A design that saved the whole group would restore a register that is too new.
- Dropped-request rule not enforced. A checkpoint asked for during a mispredict must leave the slot unchanged. A design that honours it would later restore wrong-path mappings instead of the identity.
- Flush ordering. A flush that arrives together with a mispredict and a commit must yield the committed state plus that commit. A design with the wrong priority or a registered commit path would lose the commit or take the checkpoint instead.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
  parameter int ARCH_REGS = 32;
  parameter int PHYS_REGS = 64;
  parameter int NUM_SNAP  = 4;
  parameter int LANES     = 2;

  localparam int AW = $clog2(ARCH_REGS);
  localparam int PW = $clog2(PHYS_REGS);
  localparam int TW = $clog2(NUM_SNAP);

  typedef logic [AW-1:0] areg_t;
  typedef logic [PW-1:0] preg_t;
  typedef logic [TW-1:0] tag_t;
  typedef preg_t [ARCH_REGS-1:0] map_t;

  function automatic map_t ident_map();
    map_t m;
    for (int i = 0; i < ARCH_REGS; i++) m[i] = preg_t'(i);
    return m;
  endfunction
endpackage

// File: rtl/rmt_map_write.sv
// Cumulative per-lane view of a table after each lane's write.
module rmt_map_write
  import rmt_pkg::*;
#(
  parameter int N = LANES
) (
  input  map_t            base_i,
  input  logic  [N-1:0]   we_i,
  input  areg_t [N-1:0]   rd_i,
  input  preg_t [N-1:0]   pd_i,
  output map_t  [N-1:0]   stage_o
);
  for (genvar l = 0; l < N; l++) begin : g_lane
    map_t prev;
    map_t nxt;
    if (l == 0) begin : g_first
      assign prev = base_i;
    end else begin : g_next
      assign prev = stage_o[l-1];
    end
    always_comb begin
      nxt = prev;
      if (we_i[l] && rd_i[l] != '0) nxt[rd_i[l]] = pd_i[l];
    end
    assign stage_o[l] = nxt;
  end
endmodule

// File: rtl/rmt_lane_read.sv
module rmt_lane_read
  import rmt_pkg::*;
(
  input  map_t  map_i,
  input  areg_t rs1_i,
  input  areg_t rs2_i,
  input  areg_t rd_i,
  output preg_t prs1_o,
  output preg_t prs2_o,
  output preg_t stale_o
);
  assign prs1_o  = map_i[rs1_i];
  assign prs2_o  = map_i[rs2_i];
  assign stale_o = map_i[rd_i];
endmodule

// File: rtl/rmt_snap_bank.sv
module rmt_snap_bank
  import rmt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LANES-1:0]   take_i,
  input  tag_t [LANES-1:0]   tag_i,
  input  map_t [LANES-1:0]   map_i,
  input  tag_t               rd_tag_i,
  output map_t               map_o
);
  map_t snap_q [NUM_SNAP];

  for (genvar s = 0; s < NUM_SNAP; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        snap_q[s] <= ident_map();
      end else begin
        // younger lane overrides on tag collision
        for (int l = 0; l < LANES; l++)
          if (take_i[l] && tag_i[l] == tag_t'(s)) snap_q[s] <= map_i[l];
      end
    end
  end

  assign map_o = snap_q[rd_tag_i];
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
  import rmt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic  [LANES-1:0]  ren_valid_i,
  input  logic  [LANES-1:0]  ren_wen_i,
  input  areg_t [LANES-1:0]  ren_rs1_i,
  input  areg_t [LANES-1:0]  ren_rs2_i,
  input  areg_t [LANES-1:0]  ren_rd_i,
  input  preg_t [LANES-1:0]  ren_pdst_i,
  output preg_t [LANES-1:0]  ren_prs1_o,
  output preg_t [LANES-1:0]  ren_prs2_o,
  output preg_t [LANES-1:0]  ren_stale_o,
  output logic  [LANES-1:0]  ren_stale_vld_o,
  input  logic  [LANES-1:0]  br_snap_i,
  input  tag_t  [LANES-1:0]  br_tag_i,
  input  logic               mispred_i,
  input  tag_t               mispred_tag_i,
  input  logic               flush_i,
  input  logic  [LANES-1:0]  cmt_valid_i,
  input  areg_t [LANES-1:0]  cmt_rd_i,
  input  preg_t [LANES-1:0]  cmt_pdst_i
);
  map_t spec_q, cmt_q, snap_map;
  map_t [LANES-1:0] ren_stage, cmt_stage;
  logic [LANES-1:0] ren_we;
  logic             restore;

  assign ren_we  = ren_valid_i & ren_wen_i;
  assign restore = flush_i | mispred_i;

  rmt_map_write #(.N(LANES)) u_ren_wr (
    .base_i (spec_q),
    .we_i   (ren_we),
    .rd_i   (ren_rd_i),
    .pd_i   (ren_pdst_i),
    .stage_o(ren_stage)
  );

  rmt_map_write #(.N(LANES)) u_cmt_wr (
    .base_i (cmt_q),
    .we_i   (cmt_valid_i),
    .rd_i   (cmt_rd_i),
    .pd_i   (cmt_pdst_i),
    .stage_o(cmt_stage)
  );

  rmt_snap_bank u_snap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (br_snap_i & {LANES{~restore}}),
    .tag_i   (br_tag_i),
    .map_i   (ren_stage),
    .rd_tag_i(mispred_tag_i),
    .map_o   (snap_map)
  );

  // lane l reads the table as left by lanes 0..l-1: this is the bypass
  for (genvar l = 0; l < LANES; l++) begin : g_rd
    map_t src;
    if (l == 0) begin : g_base
      assign src = spec_q;
    end else begin : g_byp
      assign src = ren_stage[l-1];
    end
    rmt_lane_read u_rd (
      .map_i  (src),
      .rs1_i  (ren_rs1_i[l]),
      .rs2_i  (ren_rs2_i[l]),
      .rd_i   (ren_rd_i[l]),
      .prs1_o (ren_prs1_o[l]),
      .prs2_o (ren_prs2_o[l]),
      .stale_o(ren_stale_o[l])
    );
    assign ren_stale_vld_o[l] = ren_we[l] && ren_rd_i[l] != '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spec_q <= ident_map();
      cmt_q  <= ident_map();
    end else begin
      cmt_q <= cmt_stage[LANES-1];
      if (flush_i)        spec_q <= cmt_stage[LANES-1];
      else if (mispred_i) spec_q <= snap_map;
      else                spec_q <= ren_stage[LANES-1];
    end
  end
endmodule

// File: rtl/rename_map_table_chk.sv
module rename_map_table_chk
  import rmt_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic  [LANES-1:0]  ren_valid_i,
  input logic  [LANES-1:0]  ren_wen_i,
  input areg_t [LANES-1:0]  ren_rs1_i,
  input areg_t [LANES-1:0]  ren_rs2_i,
  input areg_t [LANES-1:0]  ren_rd_i,
  input preg_t [LANES-1:0]  ren_pdst_i,
  input preg_t [LANES-1:0]  ren_prs1_o,
  input preg_t [LANES-1:0]  ren_prs2_o,
  input preg_t [LANES-1:0]  ren_stale_o,
  input logic  [LANES-1:0]  ren_stale_vld_o,
  input logic  [LANES-1:0]  br_snap_i,
  input tag_t  [LANES-1:0]  br_tag_i,
  input logic               mispred_i,
  input tag_t               mispred_tag_i,
  input logic               flush_i,
  input logic  [LANES-1:0]  cmt_valid_i,
  input areg_t [LANES-1:0]  cmt_rd_i,
  input preg_t [LANES-1:0]  cmt_pdst_i
);
  // R2
  x0_src_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ren_rs1_i[0] == '0 |-> ren_prs1_o[0] == '0);

  // R4
  x0_no_stale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ren_rd_i[0] == '0 |-> !ren_stale_vld_o[0]);

  // R3
  lane_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i[0] && ren_wen_i[0] && ren_rd_i[0] != '0 && ren_rs1_i[1] == ren_rd_i[0])
      |-> ren_prs1_o[1] == ren_pdst_i[0]);

  // R5
  write_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ren_valid_i[1] && ren_wen_i[1] && ren_rd_i[1] != '0 && !flush_i && !mispred_i)
      && ren_rs1_i[0] == $past(ren_rd_i[1]))
      |-> ren_prs1_o[0] == $past(ren_pdst_i[1]));
endmodule

bind rename_map_table rename_map_table_chk u_chk (.*);

// File: tb/rename_map_table_tb.sv
module rename_map_table_tb;
  import rmt_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic  [LANES-1:0] ren_valid_i, ren_wen_i, ren_stale_vld_o, br_snap_i, cmt_valid_i;
  areg_t [LANES-1:0] ren_rs1_i, ren_rs2_i, ren_rd_i, cmt_rd_i;
  preg_t [LANES-1:0] ren_pdst_i, ren_prs1_o, ren_prs2_o, ren_stale_o, cmt_pdst_i;
  tag_t  [LANES-1:0] br_tag_i;
  logic mispred_i, flush_i;
  tag_t mispred_tag_i;

  int checks = 0, fails = 0;
  bit done = 0;
  int spec_m [ARCH_REGS];
  int cmt_m  [ARCH_REGS];
  int snap_m [NUM_SNAP][ARCH_REGS];

  localparam int NV = 8;
  localparam int VA [NV] = '{1, 2, 3, 31, 17, 2, 8, 30};
  localparam int VP [NV] = '{33, 34, 35, 63, 49, 36, 40, 62};

  always #2 clk = ~clk;

  rename_map_table u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ren_valid_i(ren_valid_i), .ren_wen_i(ren_wen_i),
    .ren_rs1_i(ren_rs1_i), .ren_rs2_i(ren_rs2_i), .ren_rd_i(ren_rd_i), .ren_pdst_i(ren_pdst_i),
    .ren_prs1_o(ren_prs1_o), .ren_prs2_o(ren_prs2_o), .ren_stale_o(ren_stale_o),
    .ren_stale_vld_o(ren_stale_vld_o),
    .br_snap_i(br_snap_i), .br_tag_i(br_tag_i),
    .mispred_i(mispred_i), .mispred_tag_i(mispred_tag_i), .flush_i(flush_i),
    .cmt_valid_i(cmt_valid_i), .cmt_rd_i(cmt_rd_i), .cmt_pdst_i(cmt_pdst_i)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ren_valid_i = '0; ren_wen_i = '0; ren_rs1_i = '0; ren_rs2_i = '0;
    ren_rd_i = '0; ren_pdst_i = '0; br_snap_i = '0; br_tag_i = '0;
    mispred_i = 0; mispred_tag_i = '0; flush_i = 0;
    cmt_valid_i = '0; cmt_rd_i = '0; cmt_pdst_i = '0;
  endtask

  task automatic ren(int l, int rd, int pd);
    ren_valid_i[l] = 1; ren_wen_i[l] = 1;
    ren_rd_i[l] = areg_t'(rd); ren_pdst_i[l] = preg_t'(pd);
  endtask

  task automatic cmt(int l, int rd, int pd);
    cmt_valid_i[l] = 1; cmt_rd_i[l] = areg_t'(rd); cmt_pdst_i[l] = preg_t'(pd);
  endtask

  // reference model from the requirements, then one clock
  task automatic tick();
    int nc [ARCH_REGS];
    int s0 [ARCH_REGS];
    int s1 [ARCH_REGS];
    nc = cmt_m;
    for (int l = 0; l < LANES; l++)
      if (cmt_valid_i[l] && cmt_rd_i[l] != 0) nc[cmt_rd_i[l]] = int'(cmt_pdst_i[l]);
    s0 = spec_m;
    if (ren_valid_i[0] && ren_wen_i[0] && ren_rd_i[0] != 0) s0[ren_rd_i[0]] = int'(ren_pdst_i[0]);
    s1 = s0;
    if (ren_valid_i[1] && ren_wen_i[1] && ren_rd_i[1] != 0) s1[ren_rd_i[1]] = int'(ren_pdst_i[1]);
    if (flush_i) spec_m = nc;
    else if (mispred_i) spec_m = snap_m[mispred_tag_i];
    else begin
      if (br_snap_i[0]) snap_m[br_tag_i[0]] = s0;
      if (br_snap_i[1]) snap_m[br_tag_i[1]] = s1;
      spec_m = s1;
    end
    cmt_m = nc;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic rd_chk(int a, string req);
    ren_rs1_i[0] = areg_t'(a);
    ren_rs2_i[1] = areg_t'(a);
    #1;
    chk(req, int'(ren_prs1_o[0]), spec_m[a]);
    chk(req, int'(ren_prs2_o[1]), spec_m[a]);
    ren_rs1_i[0] = '0;
    ren_rs2_i[1] = '0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    for (int i = 0; i < ARCH_REGS; i++) begin
      spec_m[i] = i; cmt_m[i] = i;
      for (int s = 0; s < NUM_SNAP; s++) snap_m[s][i] = i;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1: identity after reset
    for (int a = 0; a < ARCH_REGS; a++) begin
      ren_rs1_i[0] = areg_t'(a); #1;
      chk("R1", int'(ren_prs1_o[0]), a);
    end
    idle();

    // R4/R5: vector table of lane 0 writes, stale checked against prior mapping
    for (int i = 0; i < NV; i++) begin
      ren(0, VA[i], VP[i]);
      #1;
      chk("R4", int'(ren_stale_o[0]), spec_m[VA[i]]);
      chk("R4", int'(ren_stale_vld_o[0]), 1);
      tick();
    end
    chk("R5", spec_m[2], 36);
    for (int a = 0; a < ARCH_REGS; a++) rd_chk(a, "R5");

    // R3: bypass to lane 1 sources and stale; R5: lane 1 wins
    ren(0, 5, 40); ren(1, 5, 41);
    ren_rs1_i[1] = 5; ren_rs2_i[1] = 5;
    #1;
    chk("R3", int'(ren_prs1_o[1]), 40);
    chk("R3", int'(ren_prs2_o[1]), 40);
    chk("R3", int'(ren_stale_o[1]), 40);
    chk("R4", int'(ren_stale_o[0]), 5);
    tick();
    rd_chk(5, "R5");
    chk("R5", spec_m[5], 41);

    // R2/R4: writes to x0 ignored, no bypass of x0
    ren(0, 0, 50); ren(1, 0, 51);
    ren_rs1_i[1] = 0;
    #1;
    chk("R4", int'(ren_stale_vld_o), 0);
    chk("R2", int'(ren_prs1_o[1]), 0);
    ren_valid_i[1] = 0;
    #1;
    chk("R4", int'(ren_stale_vld_o[1]), 0);
    ren_valid_i[1] = 1;
    tick();
    rd_chk(0, "R2");
    chk("R2", spec_m[0], 0);

    // R6/R7: per-lane checkpoints, then restore
    ren(0, 3, 20); br_snap_i[0] = 1; br_tag_i[0] = 1;
    ren(1, 4, 21); br_snap_i[1] = 1; br_tag_i[1] = 2;
    tick();
    ren(0, 3, 22); ren(1, 4, 23);
    tick();
    rd_chk(3, "R5");
    mispred_i = 1; mispred_tag_i = 1; ren(0, 6, 24);
    tick();
    rd_chk(3, "R6");
    chk("R6", spec_m[3], 20);
    rd_chk(4, "R6");
    chk("R6", spec_m[4], 41 - 41 + 4);
    rd_chk(6, "R7");
    chk("R7", spec_m[6], 6);
    mispred_i = 1; mispred_tag_i = 2;
    tick();
    rd_chk(4, "R7");
    chk("R7", spec_m[4], 21);

    // R8: checkpoint during a mispredict is dropped; slot 3 keeps identity
    mispred_i = 1; mispred_tag_i = 2;
    ren(0, 3, 25); br_snap_i[0] = 1; br_tag_i[0] = 3;
    tick();
    ren(0, 3, 26);
    tick();
    mispred_i = 1; mispred_tag_i = 3;
    tick();
    rd_chk(3, "R8");
    chk("R8", spec_m[3], 3);

    // R9: commits, lane 1 wins, x0 ignored
    cmt(0, 7, 50); cmt(1, 7, 51);
    tick();
    cmt(0, 0, 52); cmt(1, 9, 53);
    tick();
    ren(0, 9, 54); ren(1, 3, 27);
    tick();
    rd_chk(9, "R5");

    // R10: flush beats mispredict, same-cycle commit included
    flush_i = 1; mispred_i = 1; mispred_tag_i = 1;
    cmt(0, 10, 55);
    tick();
    rd_chk(7, "R9");
    chk("R9", spec_m[7], 51);
    rd_chk(9, "R10");
    chk("R10", spec_m[9], 53);
    rd_chk(10, "R10");
    chk("R10", spec_m[10], 55);
    rd_chk(3, "R10");
    chk("R10", spec_m[3], 3);
    rd_chk(0, "R9");
    for (int a = 0; a < ARCH_REGS; a++) rd_chk(a, "R10");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule